// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache that sits between a processor load/store port and a slower word memory. Every block holds one word. The word address is split so that its low bits choose a set, which is the block address modulo the number of sets. The remaining high bits form the tag. Each set has two ways. A way stores a valid flag, a dirty flag, a tag and a data word. One replacement bit per set names the way that was used less recently.

Reads and writes that hit finish in the cycle they are presented, with no stall. Writes stay in the cache and mark the line dirty. A miss stalls the processor. If the chosen victim is dirty, the cache first writes it back to memory and then reads the missing word. It completes the access in the cycle the fill is acknowledged. A write miss fetches the line first and then merges the write data into it. The processor must hold its request steady while the stall signal is high. Two counters record completed hits and completed misses.

Top module: `cache2w`

## Requirements
- R1: After reset, every line is invalid, every replacement bit and both counters are zero, `cpu_stall` and `mem_req` are low, and the first access to any address is a miss.
- R2: The set is `cpu_addr[IDX_W-1:0]` and the tag is the remaining upper bits. An access hits when a valid way of that set holds the same tag. A hit returns the line's word on `cpu_rdata` in the same cycle, with `cpu_stall` low.
- R3: On a miss, when either way of the set is invalid, the word is installed in the lowest-numbered invalid way, and the other way keeps its contents.
- R4: When both ways are valid, a miss replaces the less recently used way. Every hit and every fill makes the touched way the most recently used one, so the replacement bit then names the other way.
- R5: A write hit updates only the cached word and marks the line dirty. It starts no memory transaction, and a later read of that address returns the new word.
- R6: When the victim is valid and dirty, a memory write (`mem_we`=1) of its word to its own address {tag, set} completes before the read that fills the line. A later miss to that address returns the written-back word.
- R7: A write miss reads the line from memory, stores the CPU write data in it and marks it dirty. Replacing a clean victim causes no memory write.
- R8: `cpu_stall` is high from the cycle a miss is presented until the cycle in which the fill is acknowledged. In that cycle `cpu_stall` is low and a read returns `mem_rdata`. While `mem_req` waits for `mem_ack`, the address and direction do not change.
- R9: `hit_count` and `miss_count` each advance by one per completed access of their kind, and never both in the same cycle.
- R10: With two sets, starting from reset, the word sequence 0, 2, 0, 1, 4, 0, 2, 3, 5, 4 gives miss, miss, hit, miss, miss, hit, miss, miss, miss, miss. Address 4 evicts 2.
- R11: With two sets, starting from reset, the word sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held steady while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when the access completes |
| cpu_stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = line fill |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the transaction |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Completed misses |

## Verification
A corrupted tag or valid bit turns the next access to that set into a wrong hit or miss. That shows on `cpu_stall` in the same cycle as the request. A wrong replacement bit stays hidden until a third distinct address maps to the set. The bench therefore uses short conflict sequences over few addresses, so the victim choice is visible on the next miss. A lost dirty flag shows only when the line is evicted and read back. Every eviction is compared against a reference model, both in its write-back count and in the word that a later miss returns.

// File: rtl/cache2w_pkg.sv
`timescale 1ns/1ps
package cache2w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } cst_e;
endpackage

// File: rtl/cache2w_lookup.sv
`timescale 1ns/1ps
// Parallel tag compare across the ways of one set.
module cache2w_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 7,
    localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           req_tag,
    output logic [WAYS-1:0]            match,
    output logic                       hit,
    output logic [WW-1:0]              hit_way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == req_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WW'(w);
        end
    end
endmodule

// File: rtl/cache2w_victim.sv
`timescale 1ns/1ps
// Placement: lowest invalid way first, otherwise the less recently used way.
module cache2w_victim #(
    parameter int WAYS = 2,
    localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0] vld,
    input  logic [WW-1:0]   lru_way,
    output logic [WW-1:0]   victim
);
    logic [WW-1:0] free_way;
    logic          any_free;

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) free_way = WW'(w);
        end
        any_free = ~&vld;
        victim   = any_free ? free_way : lru_way;
    end
endmodule

// File: rtl/cache2w.sv
`timescale 1ns/1ps
module cache2w
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SETS   = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int WAYS  = 2;
    localparam int WW    = 1;
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        cst_e                                   st;
        logic [WAYS-1:0][SETS-1:0]              vld;
        logic [WAYS-1:0][SETS-1:0]              drt;
        logic [WAYS-1:0][SETS-1:0][TAG_W-1:0]   tag;
        logic [WAYS-1:0][SETS-1:0][DATA_W-1:0]  dat;
        logic [SETS-1:0]                        lru;   // way to replace next
        logic [ADDR_W-1:0]                      addr;
        logic                                   we;
        logic [DATA_W-1:0]                      wdata;
        logic [WW-1:0]                          way;
        logic [CNT_W-1:0]                       hits;
        logic [CNT_W-1:0]                       misses;
    } state_t;

    state_t s_d, s_q;

    logic [IDX_W-1:0]            cur_idx, l_idx;
    logic [TAG_W-1:0]            cur_tag, l_tag;
    logic [WAYS-1:0]             set_vld;
    logic [WAYS-1:0][TAG_W-1:0]  set_tag;
    logic [WAYS-1:0]             match;
    logic                        hit;
    logic [WW-1:0]               hit_way;
    logic [WW-1:0]               victim;

    assign cur_idx = cpu_addr[IDX_W-1:0];
    assign cur_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign l_idx   = s_q.addr[IDX_W-1:0];
    assign l_tag   = s_q.addr[ADDR_W-1:IDX_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_vld[w] = s_q.vld[w][cur_idx];
            set_tag[w] = s_q.tag[w][cur_idx];
        end
    end

    cache2w_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .vld     (set_vld),
        .tags    (set_tag),
        .req_tag (cur_tag),
        .match   (match),
        .hit     (hit),
        .hit_way (hit_way)
    );

    cache2w_victim #(.WAYS(WAYS)) u_victim (
        .vld     (set_vld),
        .lru_way (s_q.lru[cur_idx]),
        .victim  (victim)
    );

    always_comb begin
        s_d       = s_q;
        cpu_rdata = '0;
        cpu_stall = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        cpu_rdata              = s_q.dat[hit_way][cur_idx];
                        s_d.lru[cur_idx]       = ~hit_way;
                        s_d.hits               = s_q.hits + 1'b1;
                        if (cpu_we) begin
                            s_d.dat[hit_way][cur_idx] = cpu_wdata;
                            s_d.drt[hit_way][cur_idx] = 1'b1;
                        end
                    end else begin
                        cpu_stall = 1'b1;
                        s_d.addr  = cpu_addr;
                        s_d.we    = cpu_we;
                        s_d.wdata = cpu_wdata;
                        s_d.way   = victim;
                        if (s_q.vld[victim][cur_idx] && s_q.drt[victim][cur_idx])
                            s_d.st = ST_WBACK;
                        else
                            s_d.st = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {s_q.tag[s_q.way][l_idx], l_idx};
                mem_wdata = s_q.dat[s_q.way][l_idx];
                if (mem_ack) s_d.st = ST_FILL;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_addr  = s_q.addr;
                cpu_stall = ~mem_ack;
                if (mem_ack) begin
                    cpu_rdata                = mem_rdata;
                    s_d.vld[s_q.way][l_idx]  = 1'b1;
                    s_d.tag[s_q.way][l_idx]  = l_tag;
                    s_d.drt[s_q.way][l_idx]  = s_q.we;
                    s_d.dat[s_q.way][l_idx]  = s_q.we ? s_q.wdata : mem_rdata;
                    s_d.lru[l_idx]           = ~s_q.way;
                    s_d.misses               = s_q.misses + 1'b1;
                    s_d.st                   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit_count  = s_q.hits;
    assign miss_count = s_q.misses;

    // Assertions
    p_one_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && cpu_req) |-> $onehot0(match));

    p_fill_install_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_FILL && mem_ack) |=>
            (s_q.vld[$past(s_q.way)][$past(l_idx)] &&
             s_q.tag[$past(s_q.way)][$past(l_idx)] == $past(l_tag)));

    p_lru_mru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && cpu_req && hit) |=>
            (s_q.lru[$past(cur_idx)] == ~$past(hit_way)));

    p_hit_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && cpu_req && hit) |=> !mem_req);

    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_stall_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |-> cpu_stall);

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));
endmodule

// File: tb/sim_cache2w.sv
`timescale 1ns/1ps
module sim_cache2w;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NS = 2;
    localparam int CW = 16;
    localparam int MEMN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_stall;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic [CW-1:0] hit_count, miss_count;

    always #4 clk = ~clk;

    cache2w #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .CNT_W(CW)) u0 (
        .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata,
        .cpu_stall, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
        .mem_ack, .hit_count, .miss_count
    );

    int total = 0, fails = 0;
    bit done = 0;

    // backing memory and responder
    logic [DW-1:0] mem [MEMN];
    int wb_seen = 0;
    int req_cycles = 0;
    int dly = 0;

    always @(posedge clk) if (mem_req) req_cycles <= req_cycles + 1;

    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req && rst_n) begin
                if (dly == 0) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem[mem_addr];
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        wb_seen++;
                    end
                    dly = $urandom_range(0, 2);
                end else begin
                    dly--;
                end
            end
        end
    end

    // reference model
    bit            rv [2][NS];
    bit            rdt[2][NS];
    int            rt [2][NS];
    logic [DW-1:0] rdat[2][NS];
    int            rlru[NS];
    logic [DW-1:0] ref_mem [MEMN];
    int            m_hits = 0, m_misses = 0;

    task automatic model_clear();
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < NS; s++) begin
                rv[w][s] = 0; rdt[w][s] = 0; rt[w][s] = 0; rdat[w][s] = '0;
            end
        for (int s = 0; s < NS; s++) rlru[s] = 0;
        m_hits = 0; m_misses = 0;
    endtask

    task automatic model(input int a, input bit we, input logic [DW-1:0] wd,
                         output bit h, output logic [DW-1:0] rd_o, output int wb);
        int s, t, hw, vic;
        logic [DW-1:0] fill;
        s = a % NS; t = a / NS; h = 0; hw = 0; wb = 0;
        for (int w = 0; w < 2; w++)
            if (rv[w][s] && rt[w][s] == t) begin h = 1; hw = w; end
        if (h) begin
            rd_o = rdat[hw][s];
            if (we) begin rdat[hw][s] = wd; rdt[hw][s] = 1; end
            rlru[s] = 1 - hw;
            m_hits++;
        end else begin
            vic = !rv[0][s] ? 0 : (!rv[1][s] ? 1 : rlru[s]);
            if (rv[vic][s] && rdt[vic][s]) begin
                ref_mem[rt[vic][s] * NS + s] = rdat[vic][s];
                wb = 1;
            end
            fill = ref_mem[a];
            rd_o = fill;
            rdat[vic][s] = we ? wd : fill;
            rdt[vic][s] = we;
            rv[vic][s] = 1;
            rt[vic][s] = t;
            rlru[s] = 1 - vic;
            m_misses++;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // observed results of the last access
    bit            o_hit;
    int            o_wb;
    logic [DW-1:0] o_rdata;
    int            o_stall_cyc;

    task automatic do_access(input int a, input bit we, input logic [DW-1:0] wd,
                             input string req);
        bit e_hit; logic [DW-1:0] e_rd; int e_wb; int wb0; int guard;
        model(a, we, wd, e_hit, e_rd, e_wb);
        wb0 = wb_seen;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd;
        #1;
        o_hit = !cpu_stall;
        o_stall_cyc = 0;
        guard = 0;
        while (cpu_stall && guard < 200) begin
            o_stall_cyc++;
            @(negedge clk); #1;
            guard++;
        end
        o_rdata = cpu_rdata;
        o_wb = wb_seen - wb0;
        @(negedge clk);
        cpu_req = 1'b0;
        check(guard < 200, req, "stall released", guard, 0);
        check(o_hit == e_hit, req, $sformatf("hit flag addr %0d", a), o_hit, e_hit);
        if (!we) check(o_rdata == e_rd, req, $sformatf("read data addr %0d", a), o_rdata, e_rd);
        check(o_wb == e_wb, req, $sformatf("write-back count addr %0d", a), o_wb, e_wb);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_req = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state at the ports
        check(cpu_stall == 1'b0, "R1", "stall in reset", cpu_stall, 0);
        check(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
        check(hit_count == 0 && miss_count == 0, "R1", "counters in reset",
              {hit_count, miss_count}, 0);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int seq10 [10] = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
        bit exp10 [10] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0};
        int seq11 [5]  = '{0, 8, 0, 6, 8};
        bit exp11 [5]  = '{0, 0, 1, 0, 0};
        int rq0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMN; i++) begin
            mem[i]     = 32'h5A000000 ^ (i * 32'h00010203);
            ref_mem[i] = 32'h5A000000 ^ (i * 32'h00010203);
        end
        do_reset();

        // R1: first access after reset misses
        do_access(3, 0, '0, "R1");
        check(o_hit == 0, "R1", "first access misses", o_hit, 0);
        check(o_stall_cyc >= 1, "R8", "miss stalls", o_stall_cyc, 1);
        check(o_rdata == mem[3], "R8", "fill data on release", o_rdata, mem[3]);

        // R10 sequence
        do_reset();
        for (int i = 0; i < 10; i++) begin
            do_access(seq10[i], 0, '0, "R10");
            check(o_hit == exp10[i], "R10", $sformatf("step %0d hit", i), o_hit, exp10[i]);
        end
        check(hit_count == 2, "R9", "hit total after sequence", hit_count, 2);
        check(miss_count == 8, "R9", "miss total after sequence", miss_count, 8);

        // R11 sequence, R3 placement (0 and 8 coexist in set 0)
        do_reset();
        for (int i = 0; i < 5; i++) begin
            do_access(seq11[i], 0, '0, "R11");
            check(o_hit == exp11[i], "R11", $sformatf("step %0d hit", i), o_hit, exp11[i]);
        end
        do_reset();
        do_access(0, 0, '0, "R3");
        do_access(8, 0, '0, "R3");
        do_access(0, 0, '0, "R3");
        check(o_hit == 1, "R3", "second way filled, first kept", o_hit, 1);
        do_access(8, 0, '0, "R2");
        check(o_hit == 1, "R2", "hit in way 1", o_hit, 1);

        // R5 write hit
        do_reset();
        do_access(4, 0, '0, "R5");
        rq0 = req_cycles;
        do_access(4, 1, 32'h11112222, "R5");
        check(o_hit == 1, "R5", "write hit", o_hit, 1);
        check(req_cycles == rq0, "R5", "no memory traffic on write hit", req_cycles - rq0, 0);
        check(mem[4] != 32'h11112222, "R5", "memory untouched", mem[4], 0);
        do_access(4, 0, '0, "R5");
        check(o_rdata == 32'h11112222, "R5", "read after write", o_rdata, 32'h11112222);

        // R6 dirty eviction (set 0: 4 in way0 dirty, lru->way1)
        do_access(6, 0, '0, "R6");
        do_access(8, 0, '0, "R6");
        check(o_wb == 1, "R6", "dirty victim written back", o_wb, 1);
        check(mem[4] == 32'h11112222, "R6", "write-back data", mem[4], 32'h11112222);
        do_access(4, 0, '0, "R6");
        check(o_rdata == 32'h11112222, "R6", "refetch returns written word", o_rdata, 32'h11112222);
        check(o_wb == 0, "R7", "clean victim no write-back", o_wb, 0);

        // R7 write miss
        do_access(10, 1, 32'hABCD0123, "R7");
        check(o_hit == 0, "R7", "write miss", o_hit, 0);
        do_access(10, 0, '0, "R7");
        check(o_hit == 1 && o_rdata == 32'hABCD0123, "R7", "merged write data", o_rdata, 32'hABCD0123);
        do_access(12, 0, '0, "R4");
        do_access(14, 0, '0, "R7");
        check(o_wb == 1, "R7", "write-miss line is dirty", o_wb, 1);
        check(mem[10] == 32'hABCD0123, "R7", "dirty data reached memory", mem[10], 32'hABCD0123);

        // random mix, R2/R4 against the model
        do_reset();
        for (int i = 0; i < 400; i++) begin
            int a; bit we;
            a  = $urandom_range(0, 11);
            we = ($urandom_range(0, 2) == 0);
            do_access(a, we, $urandom, "R4");
        end
        check(hit_count == CW'(m_hits), "R9", "random hit total", hit_count, m_hits);
        check(miss_count == CW'(m_misses), "R9", "random miss total", miss_count, m_misses);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule